// File: doc/BRIEF.md
# NAND page ECC outcome evaluator

This block gives the verdict on a page read made with hardware error correction. When a page has landed in one of several page-sized buffer slots, a single start pulse hands the block the packed per-sector correction status words, the slot number and the page geometry. The block walks the sectors of that slot in ascending order and adds up the errors that were repaired. If a sector reports that its errors could not be repaired, the walk stops there.

An unrepairable sector does not always mean lost data. A page that was never programmed also fails the decoder, so the block then scans the slot through a synchronous byte-read port. It reads every byte of the main area and then every spare byte that holds check bytes. Only a page with at least one byte that is not 0xFF gets the uncorrectable flag. The scan stops at the first such byte. The verdict arrives as a one-cycle done pulse. The corrected total and the flag stay valid until the next verdict.

Top module: `nand_ecc_verdict`

## Requirements
- R1: Status word i occupies bits [32*i+31:32*i] of `stat_words`. Sector n takes byte (3 - n mod 4) of word n/4, with byte 3 at bits [31:24], so sector 4k is in the top byte. The error count is the low nibble of that byte, and the upper nibble is ignored.
- R2: For slot `buf_idx` = b and `steps` = s, the block examines sectors b*s up to b*s+s-1 and no others.
- R3: If no examined sector holds 15, `corr_count` is the sum of the counts (0..14), `uncorr` is 0, and no buffer read is issued.
- R4: The walk stops at the first sector whose count is 15. The counts of the sectors before it are in `corr_count`, and the counts of the sectors after it are not.
- R5: After a count of 15, the scan reads addresses base..base+P-1 and then base+P+8 .. base+P+8+s*e-1. Here base = b*2*P, P = s*SECTOR_BYTES and e = `ecc_bps`. If every byte is 0xFF, `uncorr` is 0 and exactly P+s*e reads are issued.
- R6: If any byte in the R5 range is not 0xFF, `uncorr` is 1. Spare bytes 0..7, spare bytes past the check bytes and other slots have no effect.
- R7: `done` is high for exactly one cycle, and the results are valid in that cycle. `corr_count` and `uncorr` change only together with `done`. A `start` while busy is ignored.
- R8: The read port is synchronous. `rd_data` returns the byte at `rd_addr` one cycle after a cycle with `rd_en` high.
- R9: After reset, `done`, `uncorr` and `rd_en` are 0 and `corr_count` is 0.
- R10: The scan stops issuing reads once a non-0xFF byte has come back. If the first main byte is bad, at most two reads are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that latches the inputs and begins a verdict |
| stat_words | input | STAT_WORDS*32 | Packed per-sector correction status |
| buf_idx | input | BUF_W | Buffer slot that holds the page |
| steps | input | STEP_W | Sectors per page |
| ecc_bps | input | EBPS_W | Check bytes per sector in the spare area |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | ADDR_W | Buffer byte address |
| rd_data | input | 8 | Byte returned one cycle after the strobe |
| done | output | 1 | One-cycle verdict pulse |
| corr_count | output | CNT_W | Total corrected errors |
| uncorr | output | 1 | Page holds an uncorrectable, non-erased sector |

## Verification
The bench builds the block with 32-byte sectors, four status words, up to four sectors per page and four buffer slots. This keeps full blank scans to a few hundred cycles. It still reaches every lane of the status packing, slot ranges that start in the middle of a word, and check-byte spans that end exactly at a region boundary. With 16 check bytes per sector, the spare area still holds the check bytes. This allows probes at the last scanned byte and at the first byte past it.

// File: rtl/nev_pkg.sv
package nev_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SECT  = 2'd1,
    ST_BLANK = 2'd2
  } nev_state_e;

  localparam logic [3:0] NEV_UNCORR  = 4'hF;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nev_sector_pick.sv
module nev_sector_pick #(
  parameter int STAT_WORDS = 4,
  localparam int NSEC  = STAT_WORDS * 4,
  localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic [STAT_WORDS*32-1:0] stat_words,
  input  logic [SEC_W-1:0]         sec_idx,
  output logic [3:0]               count
);

  logic [3:0] lane [NSEC];

  // Lowest sector of each word lives in the top byte.
  for (genvar s = 0; s < NSEC; s++) begin : g_lane
    localparam int LSB = 32 * (s / 4) + (3 - (s % 4)) * 8;
    assign lane[s] = stat_words[LSB +: 4];
  end

  always_comb begin
    count = 4'h0;
    for (int k = 0; k < NSEC; k++) begin
      if (sec_idx == SEC_W'(k)) count = lane[k];
    end
  end

endmodule

// File: rtl/nev_blank_scan.sv
module nev_blank_scan
  import nev_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int LEN_W      = 13,
  parameter int SPARE_SKIP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  main_len,
  input  logic [LEN_W-1:0]  ecc_len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              fin,
  output logic              erased
);

  logic             active;
  logic             data_vld;
  logic [LEN_W:0]   idx;
  logic [LEN_W:0]   total;
  logic [ADDR_W-1:0] next_addr;
  logic             more;
  logic             bad;

  assign total = {1'b0, main_len} + {1'b0, ecc_len};
  assign more  = (idx != total);
  assign bad   = data_vld && (rd_data != ERASED_BYTE);

  // Main bytes are contiguous; check bytes skip the spare header.
  always_comb begin
    if (idx < {1'b0, main_len}) next_addr = base + ADDR_W'(idx);
    else                        next_addr = base + ADDR_W'(idx) + ADDR_W'(SPARE_SKIP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      data_vld <= 1'b0;
      idx      <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      fin      <= 1'b0;
      erased   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active   <= 1'b1;
        idx      <= '0;
        data_vld <= 1'b0;
        rd_en    <= 1'b0;
      end else if (active) begin
        if (bad) begin
          active   <= 1'b0;
          fin      <= 1'b1;
          erased   <= 1'b0;
          rd_en    <= 1'b0;
          data_vld <= 1'b0;
        end else if (!more && !rd_en && !data_vld) begin
          active <= 1'b0;
          fin    <= 1'b1;
          erased <= 1'b1;
        end else begin
          rd_en    <= more;
          data_vld <= rd_en;
          if (more) begin
            rd_addr <= next_addr;
            idx     <= idx + (LEN_W+1)'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/nand_ecc_verdict.sv
module nand_ecc_verdict
  import nev_pkg::*;
#(
  parameter int SECTOR_BYTES  = 512,
  parameter int STAT_WORDS    = 4,
  parameter int MAX_STEPS     = 8,
  parameter int MAX_BUFS      = 16,
  parameter int MAX_ECC_BPS   = 16,
  parameter int ECC_SPARE_OFS = 8,
  localparam int NSEC     = STAT_WORDS * 4,
  localparam int SEC_W    = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int BUF_W    = (MAX_BUFS > 1) ? $clog2(MAX_BUFS) : 1,
  localparam int STEP_W   = $clog2(MAX_STEPS + 1),
  localparam int EBPS_W   = $clog2(MAX_ECC_BPS + 1),
  localparam int PAGE_MAX = MAX_STEPS * SECTOR_BYTES,
  localparam int ADDR_W   = $clog2(MAX_BUFS * 2 * PAGE_MAX),
  localparam int LEN_W    = $clog2(PAGE_MAX + MAX_STEPS * MAX_ECC_BPS + 1),
  localparam int CNT_W    = $clog2(14 * MAX_STEPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [STAT_WORDS*32-1:0] stat_words,
  input  logic [BUF_W-1:0]        buf_idx,
  input  logic [STEP_W-1:0]       steps,
  input  logic [EBPS_W-1:0]       ecc_bps,
  output logic                    rd_en,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic [7:0]              rd_data,
  output logic                    done,
  output logic [CNT_W-1:0]        corr_count,
  output logic                    uncorr
);

  nev_state_e               state;
  logic [STAT_WORDS*32-1:0] stat_q;
  logic [SEC_W-1:0]         sec_q;
  logic [STEP_W-1:0]        left_q;
  logic [CNT_W-1:0]         sum_q;
  logic [ADDR_W-1:0]        base_q;
  logic [LEN_W-1:0]         mlen_q;
  logic [LEN_W-1:0]         elen_q;
  logic                     scan_go;
  logic                     scan_fin;
  logic                     scan_erased;
  logic [3:0]               sec_cnt;
  logic                     busy;

  logic [SEC_W-1:0]  first_sec;
  logic [ADDR_W-1:0] base_calc;
  logic [LEN_W-1:0]  mlen_calc;
  logic [LEN_W-1:0]  elen_calc;

  assign first_sec = SEC_W'(32'(buf_idx) * 32'(steps));
  assign base_calc = ADDR_W'(32'(buf_idx) * 32'(steps) * 32'(2 * SECTOR_BYTES));
  assign mlen_calc = LEN_W'(32'(steps) * 32'(SECTOR_BYTES));
  assign elen_calc = LEN_W'(32'(steps) * 32'(ecc_bps));
  assign busy      = (state != ST_IDLE);

  nev_sector_pick #(
    .STAT_WORDS(STAT_WORDS)
  ) u_pick (
    .stat_words(stat_q),
    .sec_idx   (sec_q),
    .count     (sec_cnt)
  );

  nev_blank_scan #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .SPARE_SKIP(ECC_SPARE_OFS)
  ) u_scan (
    .clk     (clk),
    .rst     (rst),
    .go      (scan_go),
    .base    (base_q),
    .main_len(mlen_q),
    .ecc_len (elen_q),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .fin     (scan_fin),
    .erased  (scan_erased)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      stat_q     <= '0;
      sec_q      <= '0;
      left_q     <= '0;
      sum_q      <= '0;
      base_q     <= '0;
      mlen_q     <= '0;
      elen_q     <= '0;
      scan_go    <= 1'b0;
      done       <= 1'b0;
      corr_count <= '0;
      uncorr     <= 1'b0;
    end else begin
      done    <= 1'b0;
      scan_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            stat_q <= stat_words;
            sec_q  <= first_sec;
            left_q <= steps;
            sum_q  <= '0;
            base_q <= base_calc;
            mlen_q <= mlen_calc;
            elen_q <= elen_calc;
            state  <= ST_SECT;
          end
        end
        ST_SECT: begin
          if (left_q == '0) begin
            done       <= 1'b1;
            corr_count <= sum_q;
            uncorr     <= 1'b0;
            state      <= ST_IDLE;
          end else if (sec_cnt == NEV_UNCORR) begin
            scan_go <= 1'b1;
            state   <= ST_BLANK;
          end else begin
            sum_q  <= sum_q + CNT_W'(sec_cnt);
            sec_q  <= sec_q + SEC_W'(1);
            left_q <= left_q - STEP_W'(1);
          end
        end
        ST_BLANK: begin
          if (scan_fin) begin
            done       <= 1'b1;
            corr_count <= sum_q;
            uncorr     <= !scan_erased;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nev_checker.sv
module nev_checker #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 7,
  parameter int LEN_W  = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              uncorr,
  input logic [CNT_W-1:0]  corr_count,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] base_q,
  input logic [LEN_W-1:0]  mlen_q
);

  logic          rd_seen;
  logic [ADDR_W:0] win_lo;
  logic [ADDR_W:0] win_hi;

  assign win_lo = {1'b0, base_q};
  assign win_hi = {1'b0, base_q} + (ADDR_W+1)'({mlen_q, 1'b0});

  always_ff @(posedge clk) begin
    if (rst)                rd_seen <= 1'b0;
    else if (start && !busy) rd_seen <= 1'b0;
    else if (rd_en)         rd_seen <= 1'b1;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_count_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(corr_count) |-> done);

  p_hold_flag_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(uncorr) |-> done);

  p_read_window_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ({1'b0, rd_addr} >= win_lo && {1'b0, rd_addr} < win_hi));

  p_flag_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    (done && uncorr) |-> rd_seen);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!done && !rd_en && !uncorr));

endmodule

bind nand_ecc_verdict nev_checker #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .LEN_W (LEN_W)
) u_nev_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .uncorr    (uncorr),
  .corr_count(corr_count),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .base_q    (base_q),
  .mlen_q    (mlen_q)
);

// File: tb/test_nand_ecc_verdict.sv
module test_nand_ecc_verdict;

  localparam int CLK_PERIOD = 10;
  localparam int SB   = 32;
  localparam int SW   = 4;
  localparam int MS   = 4;
  localparam int MB   = 4;
  localparam int MEB  = 16;
  localparam int BUF_W  = $clog2(MB);
  localparam int STEP_W = $clog2(MS + 1);
  localparam int EBPS_W = $clog2(MEB + 1);
  localparam int ADDR_W = $clog2(MB * 2 * MS * SB);
  localparam int CNT_W  = $clog2(14 * MS + 1);
  localparam int MEM_N  = MB * 2 * MS * SB;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [SW*32-1:0]  stat_words = '0;
  logic [BUF_W-1:0]  buf_idx = '0;
  logic [STEP_W-1:0] steps = '0;
  logic [EBPS_W-1:0] ecc_bps = '0;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              done;
  logic [CNT_W-1:0]  corr_count;
  logic              uncorr;

  logic [7:0]   mem [MEM_N];
  logic [SW*32-1:0] stat;
  int checks = 0;
  int errors = 0;
  int nreads = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      nreads  <= nreads + 1;
    end
  end

  nand_ecc_verdict #(
    .SECTOR_BYTES(SB), .STAT_WORDS(SW), .MAX_STEPS(MS),
    .MAX_BUFS(MB), .MAX_ECC_BPS(MEB), .ECC_SPARE_OFS(8)
  ) i_nand_ecc_verdict (
    .clk(clk), .rst(rst), .start(start), .stat_words(stat_words),
    .buf_idx(buf_idx), .steps(steps), .ecc_bps(ecc_bps),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .corr_count(corr_count), .uncorr(uncorr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_ff();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'hFF;
  endtask

  task automatic set_sec(input int n, input logic [7:0] v);
    stat[32*(n/4) + (3 - n%4)*8 +: 8] = v;
  endtask

  task automatic clear_stat();
    stat = '0;
  endtask

  // Start one verdict and wait for done; second start mid-run if asked.
  task automatic run_op(input int b, input int st, input int eb, input bit restart,
                        output int corr, output int unc, output int reads);
    int guard;
    @(negedge clk);
    buf_idx = BUF_W'(b); steps = STEP_W'(st); ecc_bps = EBPS_W'(eb);
    stat_words = stat; nreads = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (4) @(negedge clk);
      buf_idx = BUF_W'(3); steps = STEP_W'(1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R7 done seen", int'(done), 1);
    corr = int'(corr_count); unc = int'(uncorr); reads = nreads;
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(corr_count) == corr && int'(uncorr) == unc, "R7 results held",
        int'(corr_count), corr);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R9 done after reset", int'(done), 0);
    chk(uncorr == 1'b0, "R9 uncorr after reset", int'(uncorr), 0);
    chk(corr_count == '0, "R9 count after reset", int'(corr_count), 0);
    chk(rd_en == 1'b0, "R9 no read after reset", int'(rd_en), 0);
  endtask

  task automatic t_clean();
    int c, u, r;
    fill_ff(); clear_stat();
    set_sec(3, 8'h0F); set_sec(8, 8'h0F);
    set_sec(4, 8'hA1); set_sec(5, 8'hA2); set_sec(6, 8'hA0); set_sec(7, 8'hA3);
    run_op(1, 4, 8, 1'b0, c, u, r);
    chk(c == 6, "R1 R2 R3 clean sum", c, 6);
    chk(u == 0, "R3 clean flag", u, 0);
    chk(r == 0, "R3 no reads", r, 0);
  endtask

  task automatic t_single();
    int c, u, r;
    clear_stat();
    set_sec(3, 8'h35); set_sec(2, 8'h09); set_sec(1, 8'h0F);
    run_op(3, 1, 8, 1'b0, c, u, r);
    chk(c == 5, "R1 lowest byte lane", c, 5);
    run_op(2, 1, 8, 1'b0, c, u, r);
    chk(c == 9, "R1 R2 third lane", c, 9);
    chk(u == 0, "R2 neighbour 15 ignored", u, 0);
  endtask

  task automatic t_stop_blank();
    int c, u, r;
    fill_ff(); clear_stat();
    set_sec(0, 8'h02); set_sec(1, 8'h04); set_sec(2, 8'h0F); set_sec(3, 8'h07);
    run_op(0, 4, 8, 1'b0, c, u, r);
    chk(c == 6, "R4 sum before stop", c, 6);
    chk(u == 0, "R5 erased page forgiven", u, 0);
    chk(r == 4*SB + 32, "R5 full scan read count", r, 4*SB + 32);
  endtask

  task automatic t_prog();
    int c, u, r;
    fill_ff(); mem[4*SB - 1] = 8'h00;
    run_op(0, 4, 8, 1'b0, c, u, r);
    chk(u == 1, "R6 last main byte programmed", u, 1);
    chk(c == 6, "R4 sum kept when flagged", c, 6);
    fill_ff(); mem[4*SB + 8 + 31] = 8'h7F;
    run_op(0, 4, 8, 1'b0, c, u, r);
    chk(u == 1, "R5 R6 last check byte programmed", u, 1);
  endtask

  task automatic t_outside();
    int c, u, r;
    fill_ff();
    for (int i = 0; i < 8; i++) mem[4*SB + i] = 8'h00;
    mem[4*SB + 8 + 32] = 8'h00;
    mem[8*SB] = 8'h00;
    run_op(0, 4, 8, 1'b0, c, u, r);
    chk(u == 0, "R6 bytes outside range ignored", u, 0);
  endtask

  task automatic t_early();
    int c, u, r;
    fill_ff(); mem[0] = 8'h00;
    run_op(0, 4, 8, 1'b0, c, u, r);
    chk(u == 1, "R10 first byte programmed", u, 1);
    chk(r >= 1 && r <= 2, "R10 R8 early exit reads", r, 2);
  endtask

  task automatic t_wide();
    int c, u, r;
    clear_stat(); set_sec(2, 8'h0F); set_sec(3, 8'h01);
    fill_ff(); mem[4*SB + 2*SB + 8 + 31] = 8'h00;
    run_op(1, 2, 16, 1'b0, c, u, r);
    chk(u == 1, "R5 wide check end byte", u, 1);
    chk(c == 0, "R4 stop at first sector", c, 0);
    fill_ff(); mem[4*SB + 2*SB + 8 + 32] = 8'h00;
    run_op(1, 2, 16, 1'b0, c, u, r);
    chk(u == 0, "R6 byte past wide checks ignored", u, 0);
    chk(r == 2*SB + 32, "R5 wide read count", r, 2*SB + 32);
  endtask

  task automatic t_busy_start();
    int c, u, r;
    fill_ff(); clear_stat();
    set_sec(0, 8'h02); set_sec(1, 8'h04); set_sec(2, 8'h0F); set_sec(3, 8'h35);
    run_op(0, 4, 8, 1'b1, c, u, r);
    chk(c == 6, "R7 start while busy ignored", c, 6);
    chk(r == 4*SB + 32, "R7 scan unchanged by restart", r, 4*SB + 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_stop_blank();
    t_prog();
    t_outside();
    t_early();
    t_wide();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule